// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Overrides

This block is an 8-bit general-purpose I/O port. Software sets each pin's direction and its output or pull-up bit through a small register bus, and reads the pins back through a two-flop synchronizer. A pin-change detector watches the synchronized pins under an enable mask and raises a sticky flag and an interrupt request.

Two other agents can take pins away from software. An SPI peripheral takes its serial clock, its master data in and out, and its slave select pin. Which pins are forced to input depends on whether it runs as master or slave. A clock-source selection can claim pin 6 or pin 7 as a clock input. A claimed pin then stops acting as I/O and reads zero everywhere. Pull-ups on SPI-forced inputs stay under software control through the output register.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0, `pad_pu` is 0 and `pc_irq` is 0.
- R2: With `spi_en`=1 and `spi_master`=0, pins 5 (serial clock) and 2 (slave select) are inputs whatever their direction bits hold. Pin 4 carries `spi_miso_o` on `pad_out[4]` and is driven only when its direction bit is 1.
- R3: With `spi_en`=1 and `spi_master`=1, pin 4 is an input whatever its direction bit holds. `pad_out[5]` carries `spi_sck_o` and `pad_out[3]` carries `spi_mosi_o`. Each of those two pins is driven when its direction bit is 1.
- R4: With `spi_en`=0 and no clock claim, `pad_oe` equals the direction register and `pad_out` equals the output register.
- R5: `pad_pu[i]` is 1 exactly when pin i is not driven, output register bit i is 1, `pud` is 0 and the pin is not claimed for the clock. This includes pins forced to input by the SPI.
- R6: When `clk_pin6` or `clk_pin7` is 1, that pin has `pad_oe`, `pad_out`, `pad_pu` and `pin_sync` at 0. Its bit also reads 0 in the direction, output and pin registers.
- R7: `pin_sync` follows `pad_in` after exactly two rising clock edges. It can be read at register address 2.
- R8: A change of an enabled synchronized pin sets its flag bit at the edge after `pin_sync` changes. The flag stays set, and `pc_irq` is the OR of all flags. Changes on pins whose enable bit is 0 set nothing.
- R9: Writing the flag register (address 4) clears each flag bit written as 1 and leaves the bits written as 0 unchanged.
- R10: Register addresses: 0 direction, 1 output/pull-up, 2 pins (read only), 3 change enable, 4 change flags. Addresses 5 to 7 read 0. `rdata` is loaded at the edge where `rd_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| spi_en | input | 1 | SPI peripheral enabled |
| spi_master | input | 1 | 1 = SPI master, 0 = slave |
| spi_sck_o | input | 1 | Serial clock from SPI (master) |
| spi_mosi_o | input | 1 | Master data out from SPI |
| spi_miso_o | input | 1 | Slave data out from SPI |
| clk_pin6 | input | 1 | Pin 6 claimed as clock input |
| clk_pin7 | input | 1 | Pin 7 claimed as clock input |
| pud | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pin_sync | output | 8 | Synchronized pin values |
| pc_irq | output | 1 | Pin-change interrupt request |

## Verification
The bench sweeps all 256 direction patterns through every combination of SPI enable, SPI role, pull-up disable and the two clock claims. Each pass uses varied output-register values and SPI signal levels, so these faults are exposed:
- a design that swapped the master and slave forcing of pins 4 and 5;
- a design that forgot the slave-select force;
- a design that dropped pull-ups on SPI-forced inputs;
- a design that leaked a claimed clock pin into a readback.

Synchronizer latency is sampled one edge early and on time, which catches a missing or extra stage. Toggles on disabled pins must leave the flags at zero. A clear written with zero bits must leave the flags intact, which would fail if the clear were applied to the whole register.

// File: rtl/gpio_port_ovr_pkg.sv
// Shared definitions for the GPIO port with peripheral overrides.
// Assumes an 8-bit port and a 3-bit register address space.
package gpio_port_ovr_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR   = 3'd0,
        SEL_OUT   = 3'd1,
        SEL_PIN   = 3'd2,
        SEL_PCEN  = 3'd3,
        SEL_PCFLG = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
// Multi-stage synchronizer for the raw pad inputs.
// Assumes pads are asynchronous to clk. STAGES >= 2. Resets to zero.
module gpio_ovr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pad sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_mux.sv
// Combinational alternate-function override for pin direction, value and pull-up.
// Assumes the bit positions of the SPI and clock pins are given as parameters.
// The clock-claim mask arrives already decoded.
module gpio_ovr_mux #(
    parameter int W        = 8,
    parameter int SS_BIT   = 2,
    parameter int MOSI_BIT = 3,
    parameter int MISO_BIT = 4,
    parameter int SCK_BIT  = 5
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] clk_take,
    input  logic         spi_en,
    input  logic         spi_master,
    input  logic         spi_sck_o,
    input  logic         spi_mosi_o,
    input  logic         spi_miso_o,
    input  logic         pud,
    output logic [W-1:0] oe,
    output logic [W-1:0] val,
    output logic [W-1:0] pu
);
    logic [W-1:0] force_in;
    logic [W-1:0] val_pre;
    logic         is_slave;
    logic         is_master;

    assign is_slave  = spi_en && !spi_master;
    assign is_master = spi_en && spi_master;

    // Work out which pins the SPI forces to input for its current role.
    always_comb begin
        force_in = '0;
        if (is_slave) begin
            force_in[SCK_BIT] = 1'b1;
            force_in[SS_BIT]  = 1'b1;
        end
        if (is_master) force_in[MISO_BIT] = 1'b1;
    end

    // Choose the value presented on each pin: register bit or SPI signal.
    always_comb begin
        val_pre = out_q;
        if (is_master) begin
            val_pre[SCK_BIT]  = spi_sck_o;
            val_pre[MOSI_BIT] = spi_mosi_o;
        end
        if (is_slave) val_pre[MISO_BIT] = spi_miso_o;
    end

    assign oe  = dir_q & ~force_in & ~clk_take;
    assign val = val_pre & ~clk_take;
    assign pu  = ~oe & out_q & ~clk_take & {W{~pud}};
endmodule

// File: rtl/gpio_ovr_pcd.sv
// Pin-change detector with sticky, write-one-to-clear flags.
// Assumes cur_pins is already synchronized.
// If a set and a clear hit the same bit in one cycle, the set wins.
module gpio_ovr_pcd #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_pins,
    input  logic [W-1:0] enable,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags,
    output logic         irq
);
    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;
    logic [W-1:0] hit;

    assign hit = (cur_pins ^ prev_q) & enable;

    // Remember last cycle's pins and accumulate enabled changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= cur_pins;
            flag_q <= (flag_q & ~clr_mask) | hit;
        end
    end

    assign flags = flag_q;
    assign irq   = |flag_q;
endmodule

// File: rtl/gpio_port_ovr.sv
// GPIO port top: register bank, read mux, synchronizer, override and change detector.
// Assumes single-cycle write strobes and a registered read path.
// Claimed clock pins are masked on readback only; the stored bits are kept.
module gpio_port_ovr
    import gpio_port_ovr_pkg::*;
#(
    parameter int W          = PORT_W,
    parameter int AW         = ADDR_W,
    parameter int SYNC_DEPTH = 2,
    parameter int CLK_A_BIT  = 6,
    parameter int CLK_B_BIT  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          spi_en,
    input  logic          spi_master,
    input  logic          spi_sck_o,
    input  logic          spi_mosi_o,
    input  logic          spi_miso_o,
    input  logic          clk_pin6,
    input  logic          clk_pin7,
    input  logic          pud,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_pu,
    output logic [W-1:0]  pin_sync,
    output logic          pc_irq
);
    logic [W-1:0] dir_q, out_q, pcen_q, rdata_q;
    logic [W-1:0] clk_take, sync_raw, flags, clr_mask, rd_mux;

    // Decode the clock claims into a pin mask.
    always_comb begin
        clk_take = '0;
        clk_take[CLK_A_BIT] = clk_pin6;
        clk_take[CLK_B_BIT] = clk_pin7;
    end

    // Software-owned direction, output and change-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            pcen_q <= '0;
        end else if (wr_en) begin
            if (addr == SEL_DIR)  dir_q  <= wdata;
            if (addr == SEL_OUT)  out_q  <= wdata;
            if (addr == SEL_PCEN) pcen_q <= wdata;
        end
    end

    assign clr_mask = (wr_en && addr == SEL_PCFLG) ? wdata : '0;

    gpio_ovr_sync #(.W(W), .STAGES(SYNC_DEPTH)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_raw)
    );

    assign pin_sync = sync_raw & ~clk_take;

    gpio_ovr_mux #(.W(W)) mux_i (
        .dir_q      (dir_q),
        .out_q      (out_q),
        .clk_take   (clk_take),
        .spi_en     (spi_en),
        .spi_master (spi_master),
        .spi_sck_o  (spi_sck_o),
        .spi_mosi_o (spi_mosi_o),
        .spi_miso_o (spi_miso_o),
        .pud        (pud),
        .oe         (pad_oe),
        .val        (pad_out),
        .pu         (pad_pu)
    );

    gpio_ovr_pcd #(.W(W)) pcd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_pins (pin_sync),
        .enable   (pcen_q),
        .clr_mask (clr_mask),
        .flags    (flags),
        .irq      (pc_irq)
    );

    // Select the register to return, hiding claimed clock pins.
    always_comb begin
        case (addr)
            SEL_DIR:   rd_mux = dir_q & ~clk_take;
            SEL_OUT:   rd_mux = out_q & ~clk_take;
            SEL_PIN:   rd_mux = pin_sync;
            SEL_PCEN:  rd_mux = pcen_q;
            SEL_PCFLG: rd_mux = flags;
            default:   rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/gpio_port_ovr_chk.sv
// Property checker for gpio_port_ovr, bound onto every instance of the top.
// Assumes the default SPI and clock pin positions.
module gpio_port_ovr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [2:0]   addr,
    input logic         spi_en,
    input logic         spi_master,
    input logic         clk_pin7,
    input logic         pud,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] pin_sync,
    input logic         pc_irq
);
    AST_SLAVE_FORCES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> (!pad_oe[5] && !pad_oe[2])); // R2
    AST_MASTER_FORCES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> !pad_oe[4]); // R3
    AST_PULLUP_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0); // R5
    AST_PULLUP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        pud |-> (pad_pu == '0)); // R5
    AST_CLOCK_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pin7 |-> (!pad_oe[7] && !pad_pu[7] && !pad_out[7] && !pin_sync[7])); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_irq && !(wr_en && addr == 3'd4)) |=> pc_irq); // R8
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .clk_pin7   (clk_pin7),
    .pud        (pud),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu     (pad_pu),
    .pin_sync   (pin_sync),
    .pc_irq     (pc_irq)
);

// File: tb/gpio_port_ovr_tb.sv
// Self-checking bench: exhaustive direction sweep across all override modes,
// then synchronizer latency, pin-change flags and register map checks.
module gpio_port_ovr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic       spi_en = 0, spi_master = 0, spi_sck_o = 0, spi_mosi_o = 0, spi_miso_o = 0;
    logic       clk_pin6 = 0, clk_pin7 = 0, pud = 0;
    logic [7:0] pad_in = '0, pad_oe, pad_out, pad_pu, pin_sync;
    logic       pc_irq;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ovr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .spi_en(spi_en), .spi_master(spi_master),
        .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o), .spi_miso_o(spi_miso_o),
        .clk_pin6(clk_pin6), .clk_pin7(clk_pin7), .pud(pud), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pin_sync(pin_sync),
        .pc_irq(pc_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    // Expected pin controls, worked out bit by bit from R2 to R6.
    function automatic void expect_pins(input logic [7:0] d, input logic [7:0] o,
                                        output logic [7:0] eoe, output logic [7:0] ev,
                                        output logic [7:0] epu);
        for (int i = 0; i < 8; i++) begin
            bit take, forced, v;
            take   = (i == 6 && clk_pin6) || (i == 7 && clk_pin7);
            forced = spi_en && ((!spi_master && (i == 5 || i == 2)) || (spi_master && i == 4));
            v = o[i];
            if (spi_en && spi_master && i == 5) v = spi_sck_o;
            if (spi_en && spi_master && i == 3) v = spi_mosi_o;
            if (spi_en && !spi_master && i == 4) v = spi_miso_o;
            eoe[i] = d[i] && !forced && !take;
            ev[i]  = v && !take;
            epu[i] = !eoe[i] && o[i] && !pud && !take;
        end
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, eoe, ev, epu, o, take;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 pu", pad_pu, 8'h00);
        chk("R1 irq", {7'b0, pc_irq}, 8'h00);
        for (int a = 0; a < 5; a++) begin
            bus_read(a[2:0], rd);
            chk("R1 reg", rd, 8'h00);
        end

        // R2 R3 R4 R5 R6: sweep directions across every override mode
        for (int m = 0; m < 32; m++) begin
            spi_en = m[0]; spi_master = m[1]; pud = m[2]; clk_pin6 = m[3]; clk_pin7 = m[4];
            take = {clk_pin7, clk_pin6, 6'b0};
            tag = !spi_en ? "R4" : (spi_master ? "R3" : "R2");
            for (int d = 0; d < 256; d++) begin
                o = 8'((d * 37 + m * 11) ^ 8'h5A);
                spi_sck_o = d[1] ^ m[0]; spi_mosi_o = d[2]; spi_miso_o = d[3] ^ d[6];
                bus_write(3'd0, d[7:0]);
                bus_write(3'd1, o);
                expect_pins(d[7:0], o, eoe, ev, epu);
                chk({tag, " oe"}, pad_oe, eoe);
                chk({tag, " out"}, pad_out, ev);
                chk("R5 pu", pad_pu, epu);
                if (d % 32 == 5) begin
                    bus_read(3'd0, rd); chk("R6 dir readback", rd, d[7:0] & ~take);
                    bus_read(3'd1, rd); chk("R6 out readback", rd, o & ~take);
                end
            end
        end
        spi_en = 0; spi_master = 0; pud = 0; clk_pin6 = 0; clk_pin7 = 0;

        // R7: two-edge synchronizer latency
        pin_sync_latency(8'h3C);
        pin_sync_latency(8'hC3);
        pin_sync_latency(8'h00);
        bus_read(3'd2, rd); chk("R7 pin reg", rd, 8'h00);
        pad_in = 8'hFF; repeat (3) @(negedge clk);
        bus_read(3'd2, rd); chk("R7 pin reg", rd, 8'hFF);
        clk_pin6 = 1; @(negedge clk);
        chk("R6 pin_sync", pin_sync, 8'hBF);
        bus_read(3'd2, rd); chk("R6 pin reg", rd, 8'hBF);
        clk_pin6 = 0; pad_in = 8'h00; repeat (3) @(negedge clk);

        // R8: disabled pins set nothing
        bus_write(3'd3, 8'h0F);
        @(negedge clk); pad_in = 8'hF0;
        repeat (4) @(negedge clk);
        chk("R8 disabled irq", {7'b0, pc_irq}, 8'h00);
        bus_read(3'd4, rd); chk("R8 disabled flags", rd, 8'h00);

        // R8: enabled pin sets its flag one edge after pin_sync changes
        pad_in = 8'hF2;
        @(negedge clk); @(negedge clk);
        chk("R8 irq early", {7'b0, pc_irq}, 8'h00);
        @(negedge clk);
        chk("R8 irq set", {7'b0, pc_irq}, 8'h01);
        bus_read(3'd4, rd); chk("R8 flag bit", rd, 8'h02);

        // R9: zero bits leave flags alone, one bits clear
        bus_write(3'd4, 8'hFD);
        bus_read(3'd4, rd); chk("R9 keep", rd, 8'h02);
        bus_write(3'd4, 8'h02);
        bus_read(3'd4, rd); chk("R9 clear", rd, 8'h00);
        chk("R9 irq low", {7'b0, pc_irq}, 8'h00);

        // R8: every pin, both edge directions, with all pins enabled
        bus_write(3'd3, 8'hFF);
        for (int b = 0; b < 8; b++) begin
            pad_in = pad_in ^ (8'h01 << b);
            repeat (4) @(negedge clk);
            bus_read(3'd4, rd); chk("R8 per-pin flag", rd, 8'h01 << b);
            bus_write(3'd4, 8'hFF);
        end

        // R10: register map and unused addresses
        bus_write(3'd3, 8'hA6);
        bus_read(3'd3, rd); chk("R10 pcen", rd, 8'hA6);
        for (int a = 5; a < 8; a++) begin
            bus_write(a[2:0], 8'hFF);
            bus_read(a[2:0], rd); chk("R10 unused", rd, 8'h00);
        end
        bus_read(3'd3, rd); chk("R10 pcen intact", rd, 8'hA6);
        @(negedge clk); addr = 3'd3;
        @(negedge clk); chk("R10 no strobe hold", rdata, 8'hA6);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic pin_sync_latency(input logic [7:0] v);
        logic [7:0] old;
        old = pin_sync;
        pad_in = v;
        @(negedge clk); chk("R7 one edge", pin_sync, old);
        @(negedge clk); chk("R7 two edges", pin_sync, v);
    endtask
endmodule